// File: doc/BRIEF.md
# ATM Cell Header Generator

This block sits on one transmit port. It receives an octet stream in which each cell begins with a start flag, and it emits standard 53-octet cells: four header octets, one header check octet, and 48 payload octets. The input cell length is chosen per cell by a two-bit mode. In the shortest mode the input carries only the payload and the whole header comes from programmed values. In the longest mode the input carries a four-octet prefix, which the block drops.

Each of the five header fields (GFC, VPI, VCI, PT, CLP) can be replaced individually by a programmed value. The header check octet is normally computed from the outgoing header. In the modes whose input carries that octet, it can instead be passed through. Three single-shot requests let test software take the following actions on the next cell:
- corrupt the header check through an XOR mask;
- flip a bit of the payload CRC-10 field;
- replace one cell slot with an idle cell.

Each request clears itself once it has been applied. The block holds its input back with a ready signal whenever it is producing octets of its own.

Top module: `atm_hdr_gen`

## Requirements
- R1: Every output cell is exactly 53 consecutive valid octets, with the start flag on the first octet only. The start flag is never asserted without the valid flag.
- R2: Mode encoding `cfg_mode` selects the input layout. 00 is 48 octets of payload only. 01 is 52 octets: the header followed by the payload. 10 is 53 octets: the header, the check octet and the payload. 11 is 57 octets: a prefix, the header, the check octet and the payload. In every mode, the 48 payload octets appear unchanged at output octets 6 to 53.
- R3: In modes 01, 10 and 11, each set bit of `cfg_ins` replaces one header field with its programmed value. The bits map as follows: bit 0 is GFC (header bits 31:28), bit 1 is VPI (27:20), bit 2 is VCI (19:4), bit 3 is PT (3:1) and bit 4 is CLP (0). Header bit 31 is the MSB of output octet 1.
- R4: In mode 00, all four header octets come from the programmed field values, regardless of `cfg_ins`.
- R5: A generated check octet is the CRC-8 of output header octets 1 to 4, taken MSB first with polynomial x^8+x^2+x+1 and a zero initial value, then XORed with 0x55. It is always generated in modes 00 and 01.
- R6: In modes 10 and 11 with `cfg_hec_pass` set, the input check octet is sent unchanged. With `cfg_hec_pass` clear, it is replaced by the generated value.
- R7: In mode 11, the first four input octets of a cell are consumed and never sent.
- R8: A pulse on `req_hec_err` causes the next data cell with a generated check octet to carry that octet XORed with `cfg_hec_mask`. Later cells are sent without corruption.
- R9: A pulse on `req_crc_err` inverts bit 0 of output octet 53 of the next data cell that is sent while `cfg_crc_pass` is clear. Later cells are sent without corruption.
- R10: While `cfg_crc_pass` is set, output octet 53 equals the input octet, and a pending CRC error request stays pending.
- R11: A pulse on `req_idle` makes the next cell slot an idle cell: header octets 00 00 00 01, check octet 0x52, and 48 octets of 0x6A. No input is consumed during the idle cell. The input cell that was waiting follows intact, and the request then clears.
- R12: Input octets offered between cells without the start flag are consumed and discarded, and they produce no output.
- R13: During reset and on the first cycle after it, `out_valid` is low. Requests made during reset are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | Input cell layout, sampled at each cell start |
| cfg_ins | input | 5 | Per-field replace enables |
| cfg_hec_pass | input | 1 | Pass the input check octet (modes 10 and 11) |
| cfg_crc_pass | input | 1 | Leave the CRC-10 field untouched |
| cfg_hec_mask | input | 8 | XOR mask for a forced check-octet error |
| prog_gfc | input | 4 | Programmed GFC |
| prog_vpi | input | 8 | Programmed VPI |
| prog_vci | input | 16 | Programmed VCI |
| prog_pt | input | 3 | Programmed PT |
| prog_clp | input | 1 | Programmed CLP |
| req_hec_err | input | 1 | One-cycle request to corrupt the next check octet |
| req_crc_err | input | 1 | One-cycle request to corrupt the next CRC-10 field |
| req_idle | input | 1 | One-cycle request to send an idle cell in the next slot |
| in_valid | input | 1 | Input octet valid |
| in_sop | input | 1 | Input octet is the first octet of a cell |
| in_data | input | 8 | Input octet |
| in_ready | output | 1 | Block accepts the input octet this cycle |
| out_valid | output | 1 | Output octet valid |
| out_sop | output | 1 | Output octet is cell octet 1 |
| out_data | output | 8 | Output octet |

## Verification
The checker follows the output framing on every cycle. It confirms that each start flag comes with a valid octet and that a new cell starts only after 53 octets. It confirms that an idle cell carries 0x52 and the 0x6A fill, and that no input is taken while an idle cell is sent. It also confirms that the output is quiet right after reset. The following behaviours show only in the bench's scenarios, because they depend on what was sent and what was programmed:
- field-by-field replacement;
- the check octet's value;
- the prefix being dropped;
- the single-shot corruption of the check octet and of the CRC-10 field;
- the hold of a CRC request while pass-through is set.

// File: rtl/atm_hdr_pkg.sv
package atm_hdr_pkg;

  localparam int OCT_W       = 8;
  localparam int HDR_OCTETS  = 4;
  localparam int HDR_BITS    = HDR_OCTETS * OCT_W;
  localparam int NUM_FIELDS  = 5;
  localparam int NUM_REQ     = 3;

  // request slots
  localparam int REQ_HEC  = 0;
  localparam int REQ_CRC  = 1;
  localparam int REQ_IDLE = 2;

  // header field layout, index order GFC, VPI, VCI, PT, CLP
  localparam int FLD_LSB [NUM_FIELDS] = '{28, 20, 4, 1, 0};
  localparam int FLD_W   [NUM_FIELDS] = '{4, 8, 16, 3, 1};

  localparam logic [HDR_BITS-1:0] IDLE_HDR  = 32'h0000_0001;
  localparam logic [OCT_W-1:0]    IDLE_FILL = 8'h6A;
  localparam logic [OCT_W-1:0]    HEC_COSET = 8'h55;
  localparam logic [OCT_W-1:0]    HEC_POLY  = 8'h07;
  localparam logic [OCT_W-1:0]    CRC_FLIP  = 8'h01;

  typedef enum logic [1:0] {
    MODE_48 = 2'b00,
    MODE_52 = 2'b01,
    MODE_53 = 2'b10,
    MODE_57 = 2'b11
  } cell_mode_e;

  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_SKIP = 2'd1,
    ST_RUN  = 2'd2
  } gen_state_e;

endpackage

// File: rtl/atm_hdr_mask.sv
module atm_hdr_mask
  import atm_hdr_pkg::*;
(
  input  logic [NUM_FIELDS-1:0] ins_en,
  input  logic                  all_prog,
  output logic [HDR_BITS-1:0]   mask
);

  logic [HDR_BITS-1:0] part [NUM_FIELDS];

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_fld
    localparam logic [HDR_BITS-1:0] FMASK =
      ((HDR_BITS'(1) << FLD_W[f]) - HDR_BITS'(1)) << FLD_LSB[f];
    assign part[f] = ins_en[f] ? FMASK : '0;
  end

  always_comb begin
    mask = '0;
    for (int f = 0; f < NUM_FIELDS; f++) mask |= part[f];
    if (all_prog) mask = '1;
  end

endmodule

// File: rtl/atm_hec_calc.sv
module atm_hec_calc
  import atm_hdr_pkg::*;
(
  input  logic [HDR_BITS-1:0] hdr,
  output logic [OCT_W-1:0]    hec
);

  function automatic logic [OCT_W-1:0] crc8(input logic [HDR_BITS-1:0] h);
    logic [OCT_W-1:0] c;
    logic [OCT_W-1:0] b;
    c = '0;
    for (int o = HDR_OCTETS - 1; o >= 0; o--) begin
      b = h[o*OCT_W +: OCT_W];
      c = c ^ b;
      for (int k = 0; k < OCT_W; k++)
        c = c[OCT_W-1] ? ((c << 1) ^ HEC_POLY) : (c << 1);
    end
    return c;
  endfunction

  assign hec = crc8(hdr) ^ HEC_COSET;

endmodule

// File: rtl/atm_req_flag.sv
module atm_req_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic take,
  output logic pend
);

  always_ff @(posedge clk) begin
    if (rst)       pend <= 1'b0;
    else if (set)  pend <= 1'b1;
    else if (take) pend <= 1'b0;
  end

endmodule

// File: rtl/atm_hdr_gen.sv
module atm_hdr_gen
  import atm_hdr_pkg::*;
#(
  parameter int PAYLOAD_OCTETS = 48,
  parameter int PREFIX_OCTETS  = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  cfg_mode,
  input  logic [4:0]  cfg_ins,
  input  logic        cfg_hec_pass,
  input  logic        cfg_crc_pass,
  input  logic [7:0]  cfg_hec_mask,
  input  logic [3:0]  prog_gfc,
  input  logic [7:0]  prog_vpi,
  input  logic [15:0] prog_vci,
  input  logic [2:0]  prog_pt,
  input  logic        prog_clp,
  input  logic        req_hec_err,
  input  logic        req_crc_err,
  input  logic        req_idle,
  input  logic        in_valid,
  input  logic        in_sop,
  input  logic [7:0]  in_data,
  output logic        in_ready,
  output logic        out_valid,
  output logic        out_sop,
  output logic [7:0]  out_data
);

  localparam int CELL_LEN = HDR_OCTETS + 1 + PAYLOAD_OCTETS;
  localparam int POS_W    = $clog2(CELL_LEN);
  localparam int SKIP_W   = (PREFIX_OCTETS > 1) ? $clog2(PREFIX_OCTETS) : 1;
  localparam logic [POS_W-1:0]  POS_HEC   = POS_W'(HDR_OCTETS);
  localparam logic [POS_W-1:0]  POS_LAST  = POS_W'(CELL_LEN - 1);
  localparam logic [SKIP_W-1:0] SKIP_LAST = SKIP_W'(PREFIX_OCTETS - 1);

  gen_state_e          st_q;
  cell_mode_e          mode_q;
  logic [POS_W-1:0]    pos_q;
  logic [SKIP_W-1:0]   skip_q;
  logic                idle_q;
  logic [HDR_BITS-1:0] hdr_q;

  logic [HDR_BITS-1:0] prog_hdr;
  logic [HDR_BITS-1:0] fld_mask;
  logic [OCT_W-1:0]    hec_val;
  logic [NUM_REQ-1:0]  req_set, req_take, pend;

  logic             in_hdr_pos, need_in, step;
  logic             gen_hec, hec_err_now, crc_err_now;
  logic [1:0]       hsel;
  logic [4:0]       hshift;
  logic [OCT_W-1:0] prog_b, mask_b, idle_b, oct;

  assign prog_hdr = {prog_gfc, prog_vpi, prog_vci, prog_pt, prog_clp};

  atm_hdr_mask u_mask (
    .ins_en   (cfg_ins),
    .all_prog (mode_q == MODE_48),
    .mask     (fld_mask)
  );

  atm_hec_calc u_hec (
    .hdr (hdr_q),
    .hec (hec_val)
  );

  assign req_set = {req_idle, req_crc_err, req_hec_err};

  for (genvar r = 0; r < NUM_REQ; r++) begin : g_req
    atm_req_flag u_flag (
      .clk  (clk),
      .rst  (rst),
      .set  (req_set[r]),
      .take (req_take[r]),
      .pend (pend[r])
    );
  end

  // which octets of the current slot come from the input
  assign in_hdr_pos = (pos_q < POS_HEC);

  always_comb begin
    need_in = 1'b0;
    if (!idle_q) begin
      if (in_hdr_pos)           need_in = (mode_q != MODE_48);
      else if (pos_q == POS_HEC) need_in = (mode_q == MODE_53) || (mode_q == MODE_57);
      else                      need_in = 1'b1;
    end
  end

  always_comb begin
    case (st_q)
      ST_WAIT: in_ready = !pend[REQ_IDLE] && !in_sop;
      ST_SKIP: in_ready = 1'b1;
      ST_RUN:  in_ready = need_in;
      default: in_ready = 1'b0;
    endcase
  end

  assign step = (st_q == ST_RUN) && (!need_in || in_valid);

  assign gen_hec     = idle_q || (mode_q == MODE_48) || (mode_q == MODE_52) || !cfg_hec_pass;
  assign hec_err_now = pend[REQ_HEC] && !idle_q && gen_hec;
  assign crc_err_now = pend[REQ_CRC] && !idle_q && !cfg_crc_pass;

  assign req_take[REQ_HEC]  = step && (pos_q == POS_HEC) && hec_err_now;
  assign req_take[REQ_CRC]  = step && (pos_q == POS_LAST) && crc_err_now;
  assign req_take[REQ_IDLE] = (st_q == ST_WAIT) && pend[REQ_IDLE];

  // header octet select, octet 1 holds the most significant bits
  assign hsel   = 2'(HDR_OCTETS - 1) - pos_q[1:0];
  assign hshift = {hsel, 3'b000};

  always_comb begin
    prog_b = OCT_W'(prog_hdr >> hshift);
    mask_b = OCT_W'(fld_mask >> hshift);
    idle_b = OCT_W'(IDLE_HDR >> hshift);
  end

  always_comb begin
    if (in_hdr_pos) begin
      oct = idle_q ? idle_b : ((in_data & ~mask_b) | (prog_b & mask_b));
    end else if (pos_q == POS_HEC) begin
      oct = gen_hec ? (hec_val ^ (hec_err_now ? cfg_hec_mask : '0)) : in_data;
    end else begin
      oct = idle_q ? IDLE_FILL : in_data;
      if ((pos_q == POS_LAST) && crc_err_now) oct = oct ^ CRC_FLIP;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_WAIT;
      mode_q    <= MODE_53;
      pos_q     <= '0;
      skip_q    <= '0;
      idle_q    <= 1'b0;
      hdr_q     <= '0;
      out_valid <= 1'b0;
      out_sop   <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      out_sop   <= 1'b0;
      case (st_q)
        ST_WAIT: begin
          pos_q <= '0;
          if (pend[REQ_IDLE]) begin
            idle_q <= 1'b1;
            st_q   <= ST_RUN;
          end else if (in_valid && in_sop) begin
            idle_q <= 1'b0;
            mode_q <= cell_mode_e'(cfg_mode);
            skip_q <= '0;
            st_q   <= (cell_mode_e'(cfg_mode) == MODE_57) ? ST_SKIP : ST_RUN;
          end
        end
        ST_SKIP: begin
          if (in_valid) begin
            skip_q <= skip_q + 1'b1;
            if (skip_q == SKIP_LAST) st_q <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (step) begin
            out_valid <= 1'b1;
            out_sop   <= (pos_q == '0);
            out_data  <= oct;
            if (in_hdr_pos) hdr_q <= {hdr_q[HDR_BITS-OCT_W-1:0], oct};
            if (pos_q == POS_LAST) begin
              st_q   <= ST_WAIT;
              idle_q <= 1'b0;
            end else begin
              pos_q <= pos_q + 1'b1;
            end
          end
        end
        default: st_q <= ST_WAIT;
      endcase
    end
  end

endmodule

// File: rtl/atm_hdr_gen_chk.sv
module atm_hdr_gen_chk (
  input logic       clk,
  input logic       rst,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_sop,
  input logic [7:0] out_data,
  input logic       idle_q
);

  logic [5:0] cnt;
  logic       cell_idle;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      cell_idle <= 1'b0;
    end else if (out_valid) begin
      cnt <= out_sop ? 6'd1 : cnt + 6'd1;
      if (out_sop) cell_idle <= idle_q;
    end
  end

  assert_sop_valid_R1: assert property (@(posedge clk) disable iff (rst)
    out_sop |-> out_valid);

  assert_sop_spacing_R1: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_sop) |-> (cnt == 6'd0 || cnt == 6'd53));

  assert_cell_length_R1: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_sop) |-> (cnt >= 6'd1 && cnt <= 6'd52));

  assert_idle_no_input_R11: assert property (@(posedge clk) disable iff (rst)
    idle_q |-> !in_ready);

  assert_idle_hec_R11: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_sop && cell_idle && cnt == 6'd4) |-> out_data == 8'h52);

  assert_idle_fill_R11: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_sop && cell_idle && cnt >= 6'd5) |-> out_data == 8'h6A);

  assert_quiet_after_reset_R13: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !out_valid);

endmodule

bind atm_hdr_gen atm_hdr_gen_chk i_chk (
  .clk       (clk),
  .rst       (rst),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_sop   (out_sop),
  .out_data  (out_data),
  .idle_q    (idle_q)
);

// File: tb/test_atm_hdr_gen.sv
`timescale 1ns/1ps
module test_atm_hdr_gen;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  cfg_mode = 2'b10;
  logic [4:0]  cfg_ins = '0;
  logic        cfg_hec_pass = 1'b0;
  logic        cfg_crc_pass = 1'b0;
  logic [7:0]  cfg_hec_mask = '0;
  logic        req_hec_err = 1'b0, req_crc_err = 1'b0, req_idle = 1'b0;
  logic        in_valid = 1'b0, in_sop = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready, out_valid, out_sop;
  logic [7:0]  out_data;

  // programmed header: GFC A, VPI BC, VCI 1234, PT 5, CLP 1 -> ABC1234B
  localparam logic [31:0] PROG = 32'hABC1234B;
  localparam logic [31:0] IN_HDR = 32'h12345670;
  localparam logic [7:0]  IN_HEC = 8'hEE;

  always #2 clk = ~clk;

  atm_hdr_gen i_atm_hdr_gen (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_ins(cfg_ins),
    .cfg_hec_pass(cfg_hec_pass), .cfg_crc_pass(cfg_crc_pass), .cfg_hec_mask(cfg_hec_mask),
    .prog_gfc(PROG[31:28]), .prog_vpi(PROG[27:20]), .prog_vci(PROG[19:4]),
    .prog_pt(PROG[3:1]), .prog_clp(PROG[0]),
    .req_hec_err(req_hec_err), .req_crc_err(req_crc_err), .req_idle(req_idle),
    .in_valid(in_valid), .in_sop(in_sop), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_sop(out_sop), .out_data(out_data)
  );

  int n_chk = 0, n_bad = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_hec(input logic [31:0] h);
    logic [7:0] c = '0;
    for (int i = 31; i >= 0; i--) begin
      logic fb = c[7] ^ h[i];
      c = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return c ^ 8'h55;
  endfunction

  function automatic logic [7:0] pay(input int seed, input int k);
    return 8'(k * 7 + seed * 16 + 1);
  endfunction

  // output collector
  logic [7:0] cbuf [53];
  logic [7:0] cells [4][53];
  int optr = 0, n_cells = 0, frame_err = 0;

  always @(negedge clk) begin
    if (out_valid) begin
      if (out_sop) optr = 0;
      if (optr >= 53) frame_err++;
      else begin
        cbuf[optr] = out_data;
        optr++;
        if (optr == 53) begin
          for (int i = 0; i < 53; i++) cells[n_cells % 4][i] = cbuf[i];
          n_cells++;
        end
      end
    end
  end

  task automatic send_cell(input logic [1:0] m, input logic [31:0] h, input logic [7:0] hc,
                           input int seed);
    logic [7:0] q [57];
    int n = 0;
    if (m == 2'b11) for (int i = 0; i < 4; i++) begin q[n] = 8'hF0 + 8'(i); n++; end
    if (m != 2'b00) for (int i = 3; i >= 0; i--) begin q[n] = h[i*8 +: 8]; n++; end
    if (m[1]) begin q[n] = hc; n++; end
    for (int k = 0; k < 48; k++) begin q[n] = pay(seed, k); n++; end
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sop = (i == 0); in_data = q[i];
      #0.5;
      while (!in_ready) begin @(negedge clk); #0.5; end
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0;
  endtask

  task automatic wait_cells(input int target);
    for (int g = 0; g < 400 && n_cells < target; g++) @(negedge clk);
  endtask

  task automatic check_cell(input string req, input int slot, input logic [31:0] h,
                            input logic [7:0] hc, input int seed, input bit idle, input bit flip);
    logic [31:0] got_h;
    int bad = 0;
    got_h = {cells[slot][0], cells[slot][1], cells[slot][2], cells[slot][3]};
    check({req, " header"}, got_h, h);
    check({req, " hec"}, {24'd0, cells[slot][4]}, {24'd0, hc});
    for (int k = 0; k < 47; k++)
      if (cells[slot][5+k] !== (idle ? 8'h6A : pay(seed, k))) bad++;
    check({req, " payload mismatches"}, bad, 0);
    check({req, " last octet"}, {24'd0, cells[slot][52]},
          {24'd0, (idle ? 8'h6A : pay(seed, 47)) ^ {7'd0, flip}});
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: req_hec_err = 1'b1;
      1: req_crc_err = 1'b1;
      default: req_idle = 1'b1;
    endcase
    @(negedge clk);
    req_hec_err = 1'b0; req_crc_err = 1'b0; req_idle = 1'b0;
  endtask

  // {mode, ins, hec_pass, expected header}
  localparam int NV = 8;
  localparam logic [39:0] VEC [NV] = '{
    {2'b10, 5'b00000, 1'b0, 32'h12345670},  // R2 R5 plain 53
    {2'b10, 5'b00001, 1'b0, 32'hA2345670},  // R3 GFC
    {2'b01, 5'b00010, 1'b0, 32'h1BC45670},  // R3 VPI, 52 mode
    {2'b11, 5'b00100, 1'b0, 32'h12312340},  // R3 VCI, R7 prefix
    {2'b10, 5'b11000, 1'b0, 32'h1234567B},  // R3 PT and CLP
    {2'b00, 5'b00000, 1'b0, 32'hABC1234B},  // R4 48 mode
    {2'b10, 5'b11111, 1'b0, 32'hABC1234B},  // R3 all fields
    {2'b10, 5'b00000, 1'b1, 32'h12345670}   // R6 pass-through
  };

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL R1 watchdog act=%0d exp=done", n_cells);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int base;
    // R13: request during reset is dropped
    repeat (3) @(negedge clk);
    req_hec_err = 1'b1;
    @(negedge clk);
    req_hec_err = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    check("R13 out_valid after reset", {31'd0, out_valid}, 0);
    check("R13 in_ready idle", {31'd0, in_ready}, 1);
    cfg_mode = 2'b10; cfg_hec_mask = 8'h03;
    send_cell(2'b10, IN_HDR, IN_HEC, 1);
    wait_cells(1);
    check_cell("R13", 0, IN_HDR, ref_hec(IN_HDR), 1, 1'b0, 1'b0);

    // vector table walk: R2 R3 R4 R5 R6 R7
    for (int v = 0; v < NV; v++) begin
      logic [7:0] ehec;
      cfg_mode = VEC[v][39:38]; cfg_ins = VEC[v][37:33]; cfg_hec_pass = VEC[v][32];
      ehec = (VEC[v][32] && VEC[v][39]) ? IN_HEC : ref_hec(VEC[v][31:0]);
      base = n_cells;
      send_cell(VEC[v][39:38], IN_HDR, IN_HEC, v + 2);
      wait_cells(base + 1);
      check_cell($sformatf("R2 R3 R4 R5 R6 R7 row%0d", v), base % 4, VEC[v][31:0], ehec,
                 v + 2, 1'b0, 1'b0);
    end
    cfg_mode = 2'b10; cfg_ins = '0; cfg_hec_pass = 1'b0;

    // R8: forced check-octet error, one shot
    pulse(0);
    base = n_cells;
    send_cell(2'b10, IN_HDR, IN_HEC, 20);
    send_cell(2'b10, IN_HDR, IN_HEC, 21);
    wait_cells(base + 2);
    check("R8 forced hec", {24'd0, cells[base % 4][4]}, {24'd0, ref_hec(IN_HDR) ^ 8'h03});
    check("R8 next hec clean", {24'd0, cells[(base + 1) % 4][4]}, {24'd0, ref_hec(IN_HDR)});

    // R10 then R9: CRC request held while pass is set, then applied once
    cfg_crc_pass = 1'b1;
    pulse(1);
    base = n_cells;
    send_cell(2'b10, IN_HDR, IN_HEC, 22);
    wait_cells(base + 1);
    check_cell("R10 pass", base % 4, IN_HDR, ref_hec(IN_HDR), 22, 1'b0, 1'b0);
    cfg_crc_pass = 1'b0;
    send_cell(2'b10, IN_HDR, IN_HEC, 23);
    send_cell(2'b10, IN_HDR, IN_HEC, 24);
    wait_cells(base + 3);
    check_cell("R9 R10 flipped", (base + 1) % 4, IN_HDR, ref_hec(IN_HDR), 23, 1'b0, 1'b1);
    check_cell("R9 one shot", (base + 2) % 4, IN_HDR, ref_hec(IN_HDR), 24, 1'b0, 1'b0);

    // R11: idle slot, waiting cell follows intact, request clears
    pulse(2);
    base = n_cells;
    send_cell(2'b10, IN_HDR, IN_HEC, 25);
    send_cell(2'b10, IN_HDR, IN_HEC, 26);
    wait_cells(base + 3);
    check_cell("R11 idle", base % 4, 32'h00000001, 8'h52, 0, 1'b1, 1'b0);
    check_cell("R11 held cell", (base + 1) % 4, IN_HDR, ref_hec(IN_HDR), 25, 1'b0, 1'b0);
    check_cell("R11 cleared", (base + 2) % 4, IN_HDR, ref_hec(IN_HDR), 26, 1'b0, 1'b0);

    // R12: stray octets without start flag
    base = n_cells;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sop = 1'b0; in_data = 8'hC0 + 8'(i);
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (10) @(negedge clk);
    check("R12 no output from stray", n_cells, base);
    send_cell(2'b10, IN_HDR, IN_HEC, 27);
    wait_cells(base + 1);
    repeat (5) @(negedge clk);
    check("R12 one cell", n_cells, base + 1);
    check_cell("R12 cell", base % 4, IN_HDR, ref_hec(IN_HDR), 27, 1'b0, 1'b0);

    check("R1 framing errors", frame_err, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule